// File: doc/BRIEF.md
# Daisy-Chain Serializer Readout Controller

This block is the host side of an SPI link to a chain of eight-input digital serializers. A one-cycle `start` pulse runs a single chip-select transaction in SPI mode 0. In byte mode each chip in the chain returns only its eight input levels. In word mode each chip returns its input byte followed by a diagnostic byte. That diagnostic byte carries a 5-bit check code over the input byte, an overtemperature bit and an active-low undervoltage bit.

When the transaction ends, the controller registers every chip's input byte together with per-chip flags: check-code error, overtemperature, undervoltage and external fault pin. It then raises `done` for one cycle. A chip with any flag set is marked as not valid. Its input bits can then be refused at the read port, while the healthy chips in the same chain still read normally.

The mode and the ignore-undervoltage setting are captured when a transaction starts. The ignore-undervoltage setting is meant for chips whose supply makes them report undervoltage permanently. It removes both the undervoltage flag and the fault-pin flag.

Top module: `serchain_rd`

## Requirements
- R1: `sclk` idles low whenever `cs_n` is high. A `start` seen while idle pulls `cs_n` low at that clock edge. `sclk` then toggles every `half_div`+1 clock cycles, beginning low. `miso` is sampled on each rising edge of `sclk`.
- R2: A transaction clocks exactly NCHIP*16 bits when `mode16`=1 and exactly NCHIP*8 bits when `mode16`=0. `cs_n` rises on the falling `sclk` edge that follows the last sample. `mode16` and `ignore_uv` are captured at the edge that accepts `start`.
- R3: Bits arrive MSB first. In byte mode, stream byte k is the input byte of chip k. In word mode, stream byte 2k is the input byte of chip k and byte 2k+1 is its status byte. Chip k's input byte appears on `in_bits[8k+7:8k]`.
- R4: `done` is high for exactly one cycle, one cycle after `cs_n` rises. `in_bits` and all per-chip flags change only in that cycle and hold until the next `done`.
- R5: In word mode, `crc_err[k]` is set when status bits 7:3 differ from the check code of the input byte. The check code uses polynomial x^5+x^4+x^2+1, processed MSB first from a zero start.
- R6: In word mode, `overtemp[k]` equals status bit 1.
- R7: In word mode, `undervolt[k]` is set when status bit 2 is 0, unless `ignore_uv` was set at start.
- R8: `pin_fault[k]` is the fault line sampled when `done` is produced. That line is `fault_pin[0]` for every chip when `fault_shared`=1, and `fault_pin[k]` otherwise. The flag is forced to 0 when `ignore_uv` was set at start.
- R9: In byte mode, `crc_err`, `overtemp` and `undervolt` are all 0, so the fault pin is the only diagnostic.
- R10: `valid[k]` is 1 exactly when chip k has no flag set. The read port returns `rd_bit` = bit (`rd_idx` mod 8) of chip (`rd_idx` div 8), and `rd_ok` = `valid` of that chip.
- R11: A `start` that arrives while a transaction is in progress is ignored. Timing, data and flags are unaffected, and no extra transaction follows.
- R12: After reset, `cs_n`=1, `sclk`=0, `busy`=0, `done`=0, and `in_bits` and all flag and valid vectors are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one readout transaction |
| mode16 | input | 1 | 1: input and status byte per chip; 0: input byte only |
| ignore_uv | input | 1 | Suppress undervoltage and fault-pin flags |
| fault_shared | input | 1 | 1: `fault_pin[0]` serves all chips |
| fault_pin | input | NCHIP | Active-high fault lines |
| half_div | input | DIVW | SPI half period in clock cycles, minus one |
| sclk | output | 1 | SPI clock, mode 0 |
| cs_n | output | 1 | Chain chip select, active low |
| miso | input | 1 | Serial data from the chain |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| in_bits | output | NCHIP*8 | Registered input bytes, chip k at bits 8k+7:8k |
| valid | output | NCHIP | Chip has no fault |
| crc_err | output | NCHIP | Check-code mismatch |
| overtemp | output | NCHIP | Overtemperature flag |
| undervolt | output | NCHIP | Undervoltage flag |
| pin_fault | output | NCHIP | Fault-pin flag |
| rd_idx | input | $clog2(NCHIP*8) | Input number to read |
| rd_bit | output | 1 | Level of the selected input |
| rd_ok | output | 1 | Selected input's chip is valid |

## Verification
The assertions assume that `half_div`, `mode16`, `ignore_uv` and `fault_shared` stay steady while `cs_n` is low. They also assume that the fault lines are steady around the cycle that ends the transaction. A divisor that changed mid-frame would break the half-period counter, so its timing would not be defined. The stimulus changes these inputs only between transactions, and only while `busy` is low. Its serial model shifts `miso` on falling `sclk` edges, so every rising-edge sample sees settled data.

// File: rtl/serchain_rd.sv
module serchain_rd #(
  parameter int NCHIP = 4,
  parameter int DIVW  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          mode16,
  input  logic                          ignore_uv,
  input  logic                          fault_shared,
  input  logic [NCHIP-1:0]              fault_pin,
  input  logic [DIVW-1:0]               half_div,
  output logic                          sclk,
  output logic                          cs_n,
  input  logic                          miso,
  output logic                          busy,
  output logic                          done,
  output logic [NCHIP*8-1:0]            in_bits,
  output logic [NCHIP-1:0]              valid,
  output logic [NCHIP-1:0]              crc_err,
  output logic [NCHIP-1:0]              overtemp,
  output logic [NCHIP-1:0]              undervolt,
  output logic [NCHIP-1:0]              pin_fault,
  input  logic [$clog2(NCHIP*8)-1:0]    rd_idx,
  output logic                          rd_bit,
  output logic                          rd_ok
);
  localparam int NIN  = NCHIP * 8;
  localparam int MAXB = NCHIP * 16;
  localparam int CW   = $clog2(MAXB + 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_END} st_t;
  st_t st;

  logic [DIVW-1:0] dcnt;
  logic [CW-1:0]   nbits;
  logic [MAXB-1:0] rx;
  logic            m16_q, ign_q;

  logic [NIN-1:0]   nxt_in;
  logic [NCHIP-1:0] nxt_crc, nxt_ot, nxt_uv, nxt_pf;

  wire [CW-1:0] blen = m16_q ? CW'(MAXB) : CW'(NIN);

  function automatic logic [4:0] chk5(input logic [7:0] d);
    logic [7:0] r;
    r = d;
    for (int i = 0; i < 8; i++)
      r = r[7] ? ({r[6:0], 1'b0} ^ 8'hA8) : {r[6:0], 1'b0};
    return r[7:3];
  endfunction

  for (genvar c = 0; c < NCHIP; c++) begin : g_chip
    wire [7:0] w_in  = rx[MAXB-1-16*c -: 8];
    wire [4:0] w_chk = rx[MAXB-9-16*c -: 5];
    wire       w_uvn = rx[MAXB-14-16*c];
    wire       w_ot  = rx[MAXB-15-16*c];
    wire [7:0] b_in  = rx[NIN-1-8*c -: 8];
    wire       w_pin = fault_shared ? fault_pin[0] : fault_pin[c];
    assign nxt_in[8*c +: 8] = m16_q ? w_in : b_in;
    assign nxt_crc[c] = m16_q && (w_chk != chk5(w_in));
    assign nxt_ot[c]  = m16_q && w_ot;
    assign nxt_uv[c]  = m16_q && !ign_q && !w_uvn;
    assign nxt_pf[c]  = !ign_q && w_pin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cs_n      <= 1'b1;
      sclk      <= 1'b0;
      dcnt      <= '0;
      nbits     <= '0;
      rx        <= '0;
      m16_q     <= 1'b0;
      ign_q     <= 1'b0;
      done      <= 1'b0;
      in_bits   <= '0;
      valid     <= '0;
      crc_err   <= '0;
      overtemp  <= '0;
      undervolt <= '0;
      pin_fault <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st    <= S_SHIFT;
          cs_n  <= 1'b0;
          sclk  <= 1'b0;
          dcnt  <= '0;
          nbits <= '0;
          m16_q <= mode16;
          ign_q <= ignore_uv;
        end
        S_SHIFT: begin
          if (dcnt == half_div) begin
            dcnt <= '0;
            sclk <= ~sclk;
            if (!sclk) begin
              rx    <= {rx[MAXB-2:0], miso};
              nbits <= nbits + 1'b1;
            end else if (nbits == blen) begin
              cs_n <= 1'b1;
              st   <= S_END;
            end
          end else begin
            dcnt <= dcnt + 1'b1;
          end
        end
        default: begin
          st        <= S_IDLE;
          done      <= 1'b1;
          in_bits   <= nxt_in;
          crc_err   <= nxt_crc;
          overtemp  <= nxt_ot;
          undervolt <= nxt_uv;
          pin_fault <= nxt_pf;
          valid     <= ~(nxt_crc | nxt_ot | nxt_uv | nxt_pf);
        end
      endcase
    end
  end

  assign busy   = (st != S_IDLE);
  assign rd_bit = in_bits[rd_idx];
  assign rd_ok  = valid[rd_idx >> 3];

  a_r1_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  a_r2_bit_bound: assert property (@(posedge clk) disable iff (!rst_n)
    nbits <= blen);
  a_r4_done_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> done);
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(valid) && $stable(in_bits) && $stable(crc_err)));
  a_r9_byte_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !m16_q) |-> ((crc_err | overtemp | undervolt) == '0));
  a_r8_ignore_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ign_q) |-> (undervolt == '0 && pin_fault == '0));
  a_r10_valid_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (valid & (crc_err | overtemp | undervolt | pin_fault)) == '0);
  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> busy || done);
endmodule

// File: tb/sim_serchain_rd.sv
`timescale 1ns/1ps
module sim_serchain_rd;
  localparam int N = 4;
  logic clk = 0, rst_n = 0, start = 0, mode16 = 0, ignore_uv = 0, fault_shared = 0, miso = 0;
  logic [N-1:0] fault_pin = '0;
  logic [7:0] half_div = '0;
  logic sclk, cs_n, busy, done, rd_bit, rd_ok;
  logic [N*8-1:0] in_bits;
  logic [N-1:0] valid, crc_err, overtemp, undervolt, pin_fault;
  logic [4:0] rd_idx = '0;

  serchain_rd #(.NCHIP(N), .DIVW(8)) u0 (.*);

  always #10 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] ref_code(input logic [7:0] d);
    logic [12:0] v;
    v = {d, 5'b0};
    for (int i = 12; i >= 5; i--)
      if (v[i]) v = v ^ (13'b110101 << (i - 5));
    return v[4:0];
  endfunction

  logic [7:0] inb [N];
  logic [7:0] stb [N];
  bit sbits [0:127];
  int slen = 0, bidx = 0;

  always @(negedge cs_n) begin bidx = 0; miso = sbits[0]; end
  always @(negedge sclk) if (!cs_n) begin
    bidx++;
    if (bidx < slen) miso = sbits[bidx];
  end

  int exp_done = -1, cs_a = -1, cs_b = -2;
  logic [N*8-1:0] e_in = '0, p_in = '0;
  logic [N-1:0] e_val = '0, e_crc = '0, e_ot = '0, e_uv = '0, e_pf = '0;
  logic [N-1:0] p_val, p_crc, p_ot, p_uv, p_pf;
  bit running = 0;

  always @(negedge clk) if (running) begin
    if (cyc == exp_done) begin
      e_in = p_in; e_val = p_val; e_crc = p_crc; e_ot = p_ot; e_uv = p_uv; e_pf = p_pf;
    end
    chk(done == (cyc == exp_done), "R4", "done pulse", done, cyc == exp_done);
    chk(cs_n == !(cyc >= cs_a && cyc <= cs_b), "R2", "cs_n window", cs_n, !(cyc >= cs_a && cyc <= cs_b));
    if (cs_n) chk(sclk == 0, "R1", "sclk idle", sclk, 0);
    chk(in_bits == e_in, "R3", "in_bits", in_bits, e_in);
    chk(crc_err == e_crc, "R5", "crc_err", crc_err, e_crc);
    chk(overtemp == e_ot, "R6", "overtemp", overtemp, e_ot);
    chk(undervolt == e_uv, "R7", "undervolt", undervolt, e_uv);
    chk(pin_fault == e_pf, "R8", "pin_fault", pin_fault, e_pf);
    chk(valid == e_val, "R10", "valid", valid, e_val);
  end

  function automatic logic [7:0] good_stat(input logic [7:0] d);
    return {ref_code(d), 3'b100};
  endfunction

  task automatic txn(input bit m16, input bit ign, input bit shr,
                     input logic [N-1:0] pins, input int dv, input bit extra);
    int s, nb, rise;
    slen = 0;
    for (int c = 0; c < N; c++) begin
      for (int b = 7; b >= 0; b--) sbits[slen++] = inb[c][b];
      if (m16) for (int b = 7; b >= 0; b--) sbits[slen++] = stb[c][b];
    end
    nb = m16 ? N * 16 : N * 8;
    for (int c = 0; c < N; c++) begin
      p_in[8*c +: 8] = inb[c];
      p_crc[c] = m16 && (stb[c][7:3] != ref_code(inb[c]));
      p_ot[c]  = m16 && stb[c][1];
      p_uv[c]  = m16 && !ign && !stb[c][2];
      p_pf[c]  = !ign && (shr ? pins[0] : pins[c]);
      p_val[c] = !(p_crc[c] | p_ot[c] | p_uv[c] | p_pf[c]);
    end
    @(negedge clk);
    mode16 = m16; ignore_uv = ign; fault_shared = shr; fault_pin = pins;
    half_div = 8'(dv); start = 1;
    s = cyc + 1;
    cs_a = s; cs_b = s + 2 * nb * (dv + 1) - 1; exp_done = cs_b + 2;
    @(negedge clk);
    start = 0;
    rise = 0;
    if (extra) begin
      repeat (5) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    while (cyc <= exp_done) begin
      @(posedge sclk or negedge clk);
      if (sclk && !cs_n && clk) rise++;
    end
    repeat (3) @(negedge clk);
    chk(busy == 0 && cs_n == 1, "R11", "idle after frame", {busy, cs_n}, 2'b01);
    for (int n = 0; n < N * 8; n++) begin
      rd_idx = 5'(n);
      #1;
      chk(rd_bit == inb[n / 8][n % 8], "R10", "rd_bit", rd_bit, inb[n / 8][n % 8]);
      chk(rd_ok == e_val[n / 8], "R10", "rd_ok", rd_ok, e_val[n / 8]);
    end
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog timeout");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1 && sclk == 0 && busy == 0 && done == 0, "R12", "reset ctl",
        {cs_n, sclk, busy, done}, 4'b1000);
    chk(in_bits == 0 && valid == 0 && crc_err == 0 && pin_fault == 0, "R12", "reset data",
        {in_bits, valid}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    running = 1;

    // R5 R6 R7: all healthy, word mode, fastest clock
    inb = '{8'hA5, 8'h3C, 8'hFF, 8'h01};
    for (int c = 0; c < N; c++) stb[c] = good_stat(inb[c]);
    txn(1, 0, 0, 4'b0000, 0, 0);

    // R5 bad code chip1, R6 overtemp chip2, R7 undervoltage chip3
    inb = '{8'h00, 8'h81, 8'h7E, 8'hC3};
    for (int c = 0; c < N; c++) stb[c] = good_stat(inb[c]);
    stb[1][3] = ~stb[1][3];
    stb[2][1] = 1'b1;
    stb[3][2] = 1'b0;
    txn(1, 0, 0, 4'b0000, 2, 0);

    // R7 R8 ignore setting hides undervoltage and pin
    txn(1, 1, 0, 4'b0001, 1, 0);

    // R8 per-chip pin
    for (int c = 0; c < N; c++) stb[c] = good_stat(inb[c]);
    txn(1, 0, 0, 4'b0001, 0, 0);

    // R8 shared pin asserted: all chips fault
    txn(1, 0, 1, 4'b0001, 0, 0);
    // R8 shared pin low: per-chip line 2 not consulted
    txn(1, 0, 1, 4'b0100, 0, 0);

    // R9 byte mode: only input bytes, pin is the only diagnostic
    inb = '{8'h5A, 8'h96, 8'h0F, 8'hF0};
    for (int c = 0; c < N; c++) stb[c] = 8'h00;
    txn(0, 0, 0, 4'b0100, 1, 0);

    // R11 second start while busy
    inb = '{8'h12, 8'h34, 8'h56, 8'h78};
    txn(0, 0, 0, 4'b0000, 3, 1);

    running = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule